// File: doc/BRIEF.md
# Multiplicative Segment-ID Scrambler

This block turns a segment request into a scrambled virtual segment identifier. Each request first forms a proto identifier. For a user request it comes from a 19-bit context number and the upper effective-address bits; for a kernel request it comes from the effective address alone. The block then maps the proto identifier through a multiply by a fixed prime, reduced modulo 2^n − 1. No divider is used. The high part of the product is folded onto the low part, and a single end-around increment finishes the reduction.

Two segment sizes are selected per request. Small segments use n = 36. Large segments use n = 24. The effective address enters as its bits 63..28 only, because the lower bits never affect the identifier. The pipeline has three register stages (multiply, fold, correct) and accepts a new request on every cycle. A proto identifier equal to the all-ones modulus value is reserved: the block flags it and returns zero.

Top module: `vsid_scrambler`

## Requirements
- R1: With `in_seg1t`=0, `out_vsid` equals (proto × 200730139) mod (2^36 − 1).
- R2: With `in_seg1t`=1, `out_vsid` equals (proto × 12538073) mod (2^24 − 1), and `out_vsid[35:24]` is zero. `out_seg1t` returns the request's segment-size bit.
- R3: The proto identifier is built from effective-address bits (EA[k]) as follows.
  - User request (`in_kernel`=0), small segment: {context, EA[43:28]}.
  - User request, large segment: {context, EA[43:40]}.
  - User requests ignore EA[63:44].
  - Kernel request, small segment: EA[63:28].
  - Kernel request, large segment: EA[63:40].
- R4: The result is exact even when the folded sum (product >> n) + (product mod 2^n) reaches 2^n − 1 or more. The end-around correction covers this case. The folded sum never exceeds 2^n − 2 + 2^28 for small segments, or 2^25 − 2 for large segments.
- R5: For any non-reserved proto, `out_vsid` is never the all-ones value 2^n − 1. A proto of zero gives zero.
- R6: A proto equal to 2^n − 1 drives `out_reserved`=1 and `out_vsid`=0.
- R7: A request presented with `in_valid` at clock edge k appears with `out_valid` after edge k+3. Back-to-back requests stream out back-to-back, in order. `out_valid` is low whenever no request is due.
- R8: An active-low `rst_n` empties the pipeline at once. `out_valid` stays low until a new request has passed through all three stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_seg1t | input | 1 | 0 = small segment (n=36), 1 = large segment (n=24) |
| in_kernel | input | 1 | 1 = kernel proto from address, 0 = user proto from context |
| in_context | input | 19 | User context number |
| in_ea_hi | input | 36 | Effective address bits 63..28 |
| out_valid | output | 1 | Result present |
| out_vsid | output | 36 | Scrambled identifier |
| out_seg1t | output | 1 | Segment size of the result |
| out_reserved | output | 1 | Request used the reserved all-ones proto |

## Verification
A wrong product or a wrong fold shows as a value mismatch against the modular reference exactly three cycles after the request. A missing end-around correction shows only on products whose folded sum reaches the modulus, so the stimulus includes many of them. A lost or extra valid bit shows as a queue underflow or leftover entries, or as a latency different from three, in the same cycle it occurs. A bad reserved decode shows as a nonzero identifier or a missing flag on the all-ones requests.

// File: rtl/vsid_pkg.sv
package vsid_pkg;
  localparam int unsigned WIDE_N           = 36;
  localparam int unsigned NARROW_N         = 24;
  localparam int unsigned MULT_W           = 28;
  localparam int unsigned CTX_W            = 19;
  localparam int unsigned EA_W             = 64;
  localparam int unsigned SEG_SHIFT_WIDE   = 28;
  localparam int unsigned SEG_SHIFT_NARROW = 40;
  localparam int unsigned USER_EA_TOP      = 44;
  localparam int unsigned EAH_W            = EA_W - SEG_SHIFT_WIDE;
  localparam int unsigned PROD_W           = WIDE_N + MULT_W;
  localparam int unsigned FOLD_W           = WIDE_N + 1;

  localparam logic [MULT_W-1:0] WIDE_MULT   = 28'd200730139;
  localparam logic [MULT_W-1:0] NARROW_MULT = 28'd12538073;

  // all-ones modulus for the selected segment size
  function automatic logic [WIDE_N-1:0] vs_modmask(input logic seg1t);
    if (seg1t) return {{(WIDE_N-NARROW_N){1'b0}}, {NARROW_N{1'b1}}};
    return {WIDE_N{1'b1}};
  endfunction

  function automatic logic [PROD_W-1:0] vs_multiply(input logic [WIDE_N-1:0] proto,
                                                    input logic seg1t);
    logic [MULT_W-1:0] m;
    m = seg1t ? NARROW_MULT : WIDE_MULT;
    return PROD_W'(proto) * PROD_W'(m);
  endfunction

  // high part plus low part
  function automatic logic [FOLD_W-1:0] vs_fold(input logic [PROD_W-1:0] prod,
                                                input logic seg1t);
    logic [PROD_W-1:0] hi, lo, sum;
    if (seg1t) begin
      hi = prod >> NARROW_N;
      lo = prod & {{(PROD_W-NARROW_N){1'b0}}, {NARROW_N{1'b1}}};
    end else begin
      hi = prod >> WIDE_N;
      lo = prod & {{(PROD_W-WIDE_N){1'b0}}, {WIDE_N{1'b1}}};
    end
    sum = hi + lo;
    return sum[FOLD_W-1:0];
  endfunction

  // end-around correction: add the carry that x+1 produces at bit n
  function automatic logic [WIDE_N-1:0] vs_correct(input logic [FOLD_W-1:0] x,
                                                   input logic seg1t);
    logic [FOLD_W-1:0] inc, y;
    logic carry;
    inc   = x + FOLD_W'(1);
    carry = seg1t ? inc[NARROW_N] : inc[WIDE_N];
    y     = x + FOLD_W'(carry);
    return y[WIDE_N-1:0] & vs_modmask(seg1t);
  endfunction
endpackage

// File: rtl/vsid_proto_build.sv
module vsid_proto_build
  import vsid_pkg::*;
(
  input  logic              seg1t,
  input  logic              kernel,
  input  logic [CTX_W-1:0]  ctx,
  input  logic [EAH_W-1:0]  ea_hi,
  output logic [WIDE_N-1:0] proto,
  output logic              reserved
);
  localparam int unsigned USER_LO_W = USER_EA_TOP - SEG_SHIFT_WIDE;
  localparam int unsigned DROP      = SEG_SHIFT_NARROW - SEG_SHIFT_WIDE;

  always_comb begin
    case ({kernel, seg1t})
      2'b00:   proto = WIDE_N'({ctx, ea_hi[USER_LO_W-1:0]});
      2'b01:   proto = WIDE_N'({ctx, ea_hi[USER_LO_W-1:DROP]});
      2'b10:   proto = ea_hi;
      default: proto = WIDE_N'(ea_hi[EAH_W-1:DROP]);
    endcase
    reserved = (proto == vs_modmask(seg1t));
  end
endmodule

// File: rtl/vsid_fold_stage.sv
module vsid_fold_stage
  import vsid_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_seg1t,
  input  logic              in_rsv,
  input  logic [PROD_W-1:0] in_prod,
  output logic              out_valid,
  output logic              out_seg1t,
  output logic              out_rsv,
  output logic [FOLD_W-1:0] out_fold
);
  localparam logic [FOLD_W-1:0] WIDE_CEIL =
    (FOLD_W'(1) << WIDE_N) + (FOLD_W'(1) << MULT_W) - FOLD_W'(2);
  localparam logic [FOLD_W-1:0] NARROW_CEIL =
    (FOLD_W'(1) << (NARROW_N + 1)) - FOLD_W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_seg1t <= 1'b0;
      out_rsv   <= 1'b0;
      out_fold  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_seg1t <= in_seg1t;
        out_rsv   <= in_rsv;
        out_fold  <= vs_fold(in_prod, in_seg1t);
      end
    end
  end

  AST_FOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_fold <= (out_seg1t ? NARROW_CEIL : WIDE_CEIL))); // R4
endmodule

// File: rtl/vsid_correct_stage.sv
module vsid_correct_stage
  import vsid_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_seg1t,
  input  logic              in_rsv,
  input  logic [FOLD_W-1:0] in_fold,
  output logic              out_valid,
  output logic              out_seg1t,
  output logic              out_rsv,
  output logic [WIDE_N-1:0] out_vsid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_seg1t <= 1'b0;
      out_rsv   <= 1'b0;
      out_vsid  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_seg1t <= in_seg1t;
        out_rsv   <= in_rsv;
        out_vsid  <= in_rsv ? '0 : vs_correct(in_fold, in_seg1t);
      end
    end
  end

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_rsv) |-> (out_vsid == '0)); // R6
  AST_NEVER_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_rsv) |-> (out_vsid != vs_modmask(out_seg1t))); // R5
  AST_NARROW_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_seg1t) |-> (out_vsid[WIDE_N-1:NARROW_N] == '0)); // R2
endmodule

// File: rtl/vsid_scrambler.sv
module vsid_scrambler
  import vsid_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_seg1t,
  input  logic              in_kernel,
  input  logic [CTX_W-1:0]  in_context,
  input  logic [EAH_W-1:0]  in_ea_hi,
  output logic              out_valid,
  output logic [WIDE_N-1:0] out_vsid,
  output logic              out_seg1t,
  output logic              out_reserved
);
  logic [WIDE_N-1:0] req_proto;
  logic              req_rsv;

  logic              s1_valid, s1_seg1t, s1_rsv;
  logic [PROD_W-1:0] s1_prod;
  logic              s2_valid, s2_seg1t, s2_rsv;
  logic [FOLD_W-1:0] s2_fold;

  vsid_proto_build u_proto (
    .seg1t    (in_seg1t),
    .kernel   (in_kernel),
    .ctx      (in_context),
    .ea_hi    (in_ea_hi),
    .proto    (req_proto),
    .reserved (req_rsv)
  );

  // stage 1: multiply
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_seg1t <= 1'b0;
      s1_rsv   <= 1'b0;
      s1_prod  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_seg1t <= in_seg1t;
        s1_rsv   <= req_rsv;
        s1_prod  <= vs_multiply(req_proto, in_seg1t);
      end
    end
  end

  vsid_fold_stage u_fold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s1_valid),
    .in_seg1t  (s1_seg1t),
    .in_rsv    (s1_rsv),
    .in_prod   (s1_prod),
    .out_valid (s2_valid),
    .out_seg1t (s2_seg1t),
    .out_rsv   (s2_rsv),
    .out_fold  (s2_fold)
  );

  vsid_correct_stage u_fix (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s2_valid),
    .in_seg1t  (s2_seg1t),
    .in_rsv    (s2_rsv),
    .in_fold   (s2_fold),
    .out_valid (out_valid),
    .out_seg1t (out_seg1t),
    .out_rsv   (out_reserved),
    .out_vsid  (out_vsid)
  );

  AST_THREE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3)); // R7
  AST_RESERVED_PROTO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && req_rsv) |=> s1_rsv); // R6
endmodule

// File: tb/vsid_scrambler_tb_top.sv
module vsid_scrambler_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_seg1t = 1'b0;
  logic        in_kernel = 1'b0;
  logic [18:0] in_context = '0;
  logic [35:0] in_ea_hi = '0;
  logic        out_valid;
  logic [35:0] out_vsid;
  logic        out_seg1t;
  logic        out_reserved;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int n_corr = 0;

  typedef struct {
    logic [35:0] vsid;
    logic        rsv;
    logic        seg;
    logic        corr;
    int          cyc;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  vsid_scrambler dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_seg1t(in_seg1t),
    .in_kernel(in_kernel), .in_context(in_context), .in_ea_hi(in_ea_hi),
    .out_valid(out_valid), .out_vsid(out_vsid), .out_seg1t(out_seg1t),
    .out_reserved(out_reserved)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // reference: address reassembled and shifted, per R3
  function automatic logic [35:0] ref_proto(input logic seg, input logic kern,
                                            input logic [18:0] ctx, input logic [35:0] eahi);
    logic [63:0] ea, user_ea, p;
    ea = {eahi, 28'h0};
    user_ea = ea & ((64'd1 << 44) - 64'd1);
    if (kern) p = ea >> (seg ? 40 : 28);
    else      p = ({45'd0, ctx} << (seg ? 4 : 16)) | (user_ea >> (seg ? 40 : 28));
    return p[35:0];
  endfunction

  task automatic send(input logic seg, input logic kern, input logic [18:0] ctx,
                      input logic [35:0] eahi);
    exp_t e;
    logic [63:0] m, mul, p, x;
    logic [35:0] pr;
    @(negedge clk);
    in_valid = 1'b1; in_seg1t = seg; in_kernel = kern;
    in_context = ctx; in_ea_hi = eahi;
    pr  = ref_proto(seg, kern, ctx, eahi);
    m   = seg ? ((64'd1 << 24) - 1) : ((64'd1 << 36) - 1);
    mul = seg ? 64'd12538073 : 64'd200730139;
    p   = {28'd0, pr} * mul;
    x   = (p >> (seg ? 24 : 36)) + (p & m);
    e.rsv  = ({28'd0, pr} == m);
    e.vsid = e.rsv ? 36'd0 : 36'(p % m);
    e.seg  = seg;
    e.corr = (x >= m) && !e.rsv;
    e.cyc  = cyc;
    if (e.corr) n_corr++;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        check("R7 unexpected out_valid", 64'd1, 64'd0);
      end else begin
        exp_t e;
        string tag;
        e = q.pop_front();
        tag = e.rsv ? "R6" : (e.corr ? "R4" : (e.seg ? "R2" : "R1"));
        check({tag, " vsid"}, {28'd0, out_vsid}, {28'd0, e.vsid});
        check("R6 reserved flag", {63'd0, out_reserved}, {63'd0, e.rsv});
        check("R2 segment size", {63'd0, out_seg1t}, {63'd0, e.seg});
        check("R7 latency", 64'(cyc - e.cyc), 64'd3);
        if (!e.rsv)
          check("R5 not all-ones", {63'd0, out_vsid == (e.seg ? 36'hFFFFFF : 36'hFFFFFFFFF)}, 64'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 out_valid in reset", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    idle(2);
    check("R8 out_valid after reset", {63'd0, out_valid}, 64'd0);

    // R3 user small segment; EA[63:44] junk must be ignored
    send(1'b0, 1'b0, 19'h12345, 36'hFFF00ABCD);
    // R3 kernel small segment
    send(1'b0, 1'b1, 19'h00000, 36'hC00000123);
    // R3 user large segment, 23-bit all-ones proto: not reserved
    send(1'b1, 1'b0, 19'h7FFFF, 36'h00000F000);
    // R3 kernel large segment
    send(1'b1, 1'b1, 19'h00000, 36'hC00001ABC);
    // R5 zero proto
    send(1'b0, 1'b0, 19'h00000, 36'h000000000);
    // R1 proto one gives the multiplier
    send(1'b0, 1'b1, 19'h00000, 36'h000000001);
    // R6 reserved small and large
    send(1'b0, 1'b1, 19'h00000, 36'hFFFFFFFFF);
    send(1'b1, 1'b1, 19'h00000, 36'hFFFFFF123);
    // next to reserved
    send(1'b0, 1'b1, 19'h00000, 36'hFFFFFFFFE);
    send(1'b1, 1'b1, 19'h00000, 36'hFFFFFE000);
    idle(5);

    // R7 back-to-back stream with sporadic gaps
    for (int i = 0; i < 400; i++) begin
      send(1'($urandom), 1'($urandom), 19'($urandom), {4'($urandom), 32'($urandom)});
      if (($urandom % 8) == 0) idle(1);
    end
    idle(6);
    check("R7 queue drained", 64'(q.size()), 64'd0);
    check("R4 correction cases seen", {63'd0, n_corr > 0}, 64'd1);

    // R8 reset with requests in flight
    send(1'b0, 1'b1, 19'h0, 36'h123456789);
    send(1'b1, 1'b0, 19'h1, 36'h000000001);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    q.delete();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8 flushed in reset", {63'd0, out_valid}, 64'd0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R8 no stale output", {63'd0, out_valid}, 64'd0);
    end
    send(1'b0, 1'b0, 19'h7FFFF, 36'h00000FFFF);
    send(1'b1, 1'b0, 19'h2AAAA, 36'h000005000);
    idle(6);
    check("R7 final drain", 64'(q.size()), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule